// File: doc/BRIEF.md
# Push-Button and Power-Fail Reset Supervisor

This block supervises one active-low system reset line that is shared by a manual push button and by the block's own open-drain driver. It senses the level of that line. When the line falls while the block is not already running a reset cycle, the press is debounced by driving the line low for a set number of ticks. If the line is still low after that, the block waits for the button to be let go and then stretches a reset pulse of a set length.

A power-fail flag overrides any button activity and holds the line low for as long as it is raised. When the flag clears, the line stays low for a recovery period if the oscillator-running flag is set. It is released at once if that flag is clear.

Every duration is counted in pulses of a slow tick input (nominally one millisecond) and is set by parameter. The sensed line and both flags pass through synchronizers before the control logic uses them.

Top module: `resetSupervisor`

## Requirements
- R1: While `rstN` is low and after it rises, `driveLow` is 0 until a press or a power fail occurs.
- R2: A high-to-low change of `lineSense` while idle raises `driveLow` within four clock cycles. `driveLow` stays 1 until `DEBOUNCE_TICKS` tick pulses have been seen.
- R3: When the debounce ends with the line still low, `driveLow` returns to 0. It remains 0 for as long as the button holds the line low, however many ticks pass.
- R4: A low-to-high change of the line after R3 raises `driveLow` within four clock cycles. `driveLow` stays 1 for `PULSE_TICKS` tick pulses and then falls to 0.
- R5: When the line is already high once the block stops driving after the debounce, the block returns to idle and no stretched pulse follows.
- R6: Edges that the block causes by its own driving, and a button release seen while idle, never start a new reset cycle.
- R7: `powerFail` at 1 raises `driveLow` within four clock cycles from any state, including every button phase, and holds it while the flag stays 1.
- R8: When `powerFail` returns to 0 with `oscRunning` at 1, `driveLow` stays 1 for `RECOVER_TICKS` tick pulses and then falls. Any button phase that was interrupted by the power fail is abandoned.
- R9: When `powerFail` returns to 0 with `oscRunning` at 0, `driveLow` falls within four clock cycles.
- R10: A timer advances only on a clock cycle in which `msTick` is 1. A tick in the cycle in which a timer is loaded is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineSense | input | 1 | Sensed level of the shared reset line (0 = low) |
| powerFail | input | 1 | Power-fail comparator flag, 1 = supply below threshold |
| oscRunning | input | 1 | 1 when the timekeeping oscillator is running |
| msTick | input | 1 | One-cycle pulse once per tick period |
| driveLow | output | 1 | 1 pulls the shared reset line low |

## Verification
The overlap that matters is between the button sequence and the power-fail override. A power fail that arrives in the middle of a stretched pulse, or while the button is held, must take over the line. The timer must then restart with the recovery count, not continue with what remained of the pulse. The bench raises `powerFail` partway through a pulse, clears it with the oscillator running, and checks that the line is held for the full recovery count, which is longer than the pulse remainder. It also holds the button through a power fail that ends without an oscillator, releases the button afterwards, and checks that no pulse appears.

// File: rtl/rstSupPkg.sv
package rstSupPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEBOUNCE,
    ST_SETTLE,
    ST_WAIT_REL,
    ST_PULSE,
    ST_PFAIL,
    ST_RECOVER
  } supState_t;

  typedef enum logic [1:0] {
    LD_DEBOUNCE,
    LD_PULSE,
    LD_RECOVER,
    LD_SETTLE
  } loadSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;     // load the timer this cycle
    loadSel_t sel;      // which duration to load
    logic     stepClk;  // count clocks instead of ticks
    logic     edgeArm;  // allow edge strobes (block not driving)
  } ctrlStrobes_t;

endpackage

// File: rtl/rstSupData.sv
module rstSupData
  import rstSupPkg::*;
#(
  parameter int DEBOUNCE_TICKS = 20,
  parameter int PULSE_TICKS    = 250,
  parameter int RECOVER_TICKS  = 250,
  parameter int SYNC_STAGES    = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         lineSense,
  input  logic         powerFail,
  input  logic         oscRunning,
  input  logic         msTick,
  input  ctrlStrobes_t strobes,
  output logic         lineLow,
  output logic         fallSeen,
  output logic         riseSeen,
  output logic         pfSync,
  output logic         oscSync,
  output logic         cntZero
);

  localparam int SETTLE_CLKS = SYNC_STAGES + 2;
  localparam int MAX_A = (DEBOUNCE_TICKS > PULSE_TICKS) ? DEBOUNCE_TICKS : PULSE_TICKS;
  localparam int MAX_B = (RECOVER_TICKS > SETTLE_CLKS) ? RECOVER_TICKS : SETTLE_CLKS;
  localparam int MAX_CNT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_CNT + 1);
  localparam int N_SYNC = 3;
  localparam logic [N_SYNC-1:0] SYNC_RST = 3'b001;  // line idles high

  logic [N_SYNC-1:0] rawIn;
  logic [N_SYNC-1:0] syncOut;
  assign rawIn = {oscRunning, powerFail, lineSense};

  for (genvar ch = 0; ch < N_SYNC; ch++) begin : g_sync
    logic [SYNC_STAGES-1:0] stages;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stages <= {SYNC_STAGES{SYNC_RST[ch]}};
      else       stages <= {stages[SYNC_STAGES-2:0], rawIn[ch]};
    end
    assign syncOut[ch] = stages[SYNC_STAGES-1];
  end

  logic lineLvl, prevLvl;
  assign lineLvl = syncOut[0];
  assign pfSync  = syncOut[1];
  assign oscSync = syncOut[2];
  assign lineLow = !lineLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b1;
    else       prevLvl <= lineLvl;
  end

  assign fallSeen = strobes.edgeArm && prevLvl && !lineLvl;
  assign riseSeen = strobes.edgeArm && !prevLvl && lineLvl;

  logic [CNT_W-1:0] cnt, loadVal;

  always_comb begin
    unique case (strobes.sel)
      LD_DEBOUNCE: loadVal = CNT_W'(DEBOUNCE_TICKS);
      LD_PULSE:    loadVal = CNT_W'(PULSE_TICKS);
      LD_RECOVER:  loadVal = CNT_W'(RECOVER_TICKS);
      default:     loadVal = CNT_W'(SETTLE_CLKS);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          cnt <= '0;
    else if (strobes.load)                              cnt <= loadVal;
    else if (cnt != '0 && (msTick || strobes.stepClk))  cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  // R10: the timer moves only on a tick or a settle step
  assert_timer_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !msTick && !strobes.stepClk) |=> $stable(cnt));

  // R2: a load places a non-zero count
  assert_load_nonzero_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> !cntZero);

endmodule

// File: rtl/rstSupCtrl.sv
module rstSupCtrl
  import rstSupPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         lineLow,
  input  logic         fallSeen,
  input  logic         riseSeen,
  input  logic         pfSync,
  input  logic         oscSync,
  input  logic         cntZero,
  output ctrlStrobes_t strobes,
  output logic         driveLow
);

  supState_t state, nextState;
  logic nextDrive;

  always_comb begin
    nextState       = state;
    strobes.load    = 1'b0;
    strobes.sel     = LD_DEBOUNCE;
    strobes.stepClk = (state == ST_SETTLE);
    strobes.edgeArm = (state == ST_IDLE) || (state == ST_WAIT_REL);
    if (pfSync) begin
      nextState = ST_PFAIL;
    end else begin
      unique case (state)
        ST_IDLE: if (fallSeen) begin
          nextState    = ST_DEBOUNCE;
          strobes.load = 1'b1;
          strobes.sel  = LD_DEBOUNCE;
        end
        ST_DEBOUNCE: if (cntZero) begin
          nextState    = ST_SETTLE;
          strobes.load = 1'b1;
          strobes.sel  = LD_SETTLE;
        end
        ST_SETTLE: if (cntZero) nextState = lineLow ? ST_WAIT_REL : ST_IDLE;
        ST_WAIT_REL: if (riseSeen) begin
          nextState    = ST_PULSE;
          strobes.load = 1'b1;
          strobes.sel  = LD_PULSE;
        end
        ST_PULSE: if (cntZero) nextState = ST_IDLE;
        ST_PFAIL: begin
          if (oscSync) begin
            nextState    = ST_RECOVER;
            strobes.load = 1'b1;
            strobes.sel  = LD_RECOVER;
          end else begin
            nextState = ST_IDLE;
          end
        end
        ST_RECOVER: if (cntZero) nextState = ST_IDLE;
        default: nextState = ST_IDLE;
      endcase
    end
  end

  assign nextDrive = (nextState == ST_DEBOUNCE) || (nextState == ST_PULSE) ||
                     (nextState == ST_PFAIL)    || (nextState == ST_RECOVER);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      driveLow <= 1'b0;
    end else begin
      state    <= nextState;
      driveLow <= nextDrive;
    end
  end

  // R7: a synchronized power fail always lands in the fail state
  assert_pfail_takes_over_R7: assert property (@(posedge clk) disable iff (!rstN)
    pfSync |=> (state == ST_PFAIL) && driveLow);

  // R6: no press strobe while the block pulls the line itself
  assert_no_self_press_R6: assert property (@(posedge clk) disable iff (!rstN)
    driveLow |-> !fallSeen);

  // R4: a stretched pulse begins only from waiting for release
  assert_pulse_after_wait_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PULSE && $past(state) != ST_PULSE) |-> $past(state) == ST_WAIT_REL);

  // R9: leaving the fail state without an oscillator goes straight to idle
  assert_skip_recover_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_PFAIL && state != ST_PFAIL && !$past(oscSync)) |-> state == ST_IDLE);

  // R8: recovery is entered only with the oscillator running
  assert_recover_needs_osc_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOVER && $past(state) == ST_PFAIL) |-> $past(oscSync));

endmodule

// File: rtl/resetSupervisor.sv
module resetSupervisor
  import rstSupPkg::*;
#(
  parameter int DEBOUNCE_TICKS = 20,
  parameter int PULSE_TICKS    = 250,
  parameter int RECOVER_TICKS  = 250,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineSense,
  input  logic powerFail,
  input  logic oscRunning,
  input  logic msTick,
  output logic driveLow
);

  ctrlStrobes_t strobes;
  logic lineLow, fallSeen, riseSeen, pfSync, oscSync, cntZero;

  rstSupData #(
    .DEBOUNCE_TICKS(DEBOUNCE_TICKS),
    .PULSE_TICKS   (PULSE_TICKS),
    .RECOVER_TICKS (RECOVER_TICKS),
    .SYNC_STAGES   (SYNC_STAGES)
  ) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .lineSense (lineSense),
    .powerFail (powerFail),
    .oscRunning(oscRunning),
    .msTick    (msTick),
    .strobes   (strobes),
    .lineLow   (lineLow),
    .fallSeen  (fallSeen),
    .riseSeen  (riseSeen),
    .pfSync    (pfSync),
    .oscSync   (oscSync),
    .cntZero   (cntZero)
  );

  rstSupCtrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .lineLow (lineLow),
    .fallSeen(fallSeen),
    .riseSeen(riseSeen),
    .pfSync  (pfSync),
    .oscSync (oscSync),
    .cntZero (cntZero),
    .strobes (strobes),
    .driveLow(driveLow)
  );

  // R1: nothing drives the line while reset is held
  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rstN |=> !driveLow);

endmodule

// File: tb/test_resetSupervisor.sv
`timescale 1ns/1ps
module test_resetSupervisor;

  localparam int DEB = 4;
  localparam int PUL = 6;
  localparam int REC = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic buttonDown = 1'b0;
  logic powerFail = 1'b0;
  logic oscRunning = 1'b1;
  logic msTick = 1'b0;
  logic lineSense;
  logic driveLow;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // shared open-drain line: low if the button or the block pulls it
  assign lineSense = !(buttonDown || driveLow);

  resetSupervisor #(
    .DEBOUNCE_TICKS(DEB), .PULSE_TICKS(PUL), .RECOVER_TICKS(REC), .SYNC_STAGES(2)
  ) i_resetSupervisor (
    .clk(clk), .rstN(rstN), .lineSense(lineSense), .powerFail(powerFail),
    .oscRunning(oscRunning), .msTick(msTick), .driveLow(driveLow)
  );

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) msTick = 1'b1;
      @(negedge clk) msTick = 1'b0;
      cycles(2);
    end
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: driveLow actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic testReset;
    check("R1 during reset", driveLow, 1'b0);
    rstN = 1'b1;
    cycles(6);
    check("R1 after reset", driveLow, 1'b0);
  endtask

  task automatic testLongPress;
    buttonDown = 1'b1;
    cycles(4);
    check("R2 press drives", driveLow, 1'b1);
    cycles(20);
    check("R10 no ticks no expiry", driveLow, 1'b1);
    ticks(DEB - 1);
    check("R2 held through debounce", driveLow, 1'b1);
    ticks(1);
    cycles(2);
    check("R3 released after debounce", driveLow, 1'b0);
    ticks(PUL + 3);
    check("R3 waits while held", driveLow, 1'b0);
    buttonDown = 1'b0;
    cycles(4);
    check("R4 pulse on release", driveLow, 1'b1);
    ticks(PUL - 1);
    check("R4 pulse still held", driveLow, 1'b1);
    ticks(1);
    cycles(2);
    check("R4 pulse ends", driveLow, 1'b0);
    cycles(10);
    ticks(DEB + 2);
    check("R6 own edges ignored", driveLow, 1'b0);
  endtask

  task automatic testShortPress;
    buttonDown = 1'b1;
    cycles(4);
    check("R2 short press drives", driveLow, 1'b1);
    cycles(2);
    buttonDown = 1'b0;
    ticks(DEB);
    cycles(12);
    check("R5 no pulse after short press", driveLow, 1'b0);
    ticks(PUL + 2);
    check("R5 stays idle", driveLow, 1'b0);
  endtask

  task automatic testPowerFail;
    oscRunning = 1'b1;
    powerFail = 1'b1;
    cycles(4);
    check("R7 fail drives", driveLow, 1'b1);
    ticks(REC + 2);
    check("R7 held during fail", driveLow, 1'b1);
    powerFail = 1'b0;
    cycles(4);
    ticks(REC - 1);
    check("R8 recovery hold", driveLow, 1'b1);
    ticks(1);
    cycles(2);
    check("R8 recovery ends", driveLow, 1'b0);
    oscRunning = 1'b0;
    powerFail = 1'b1;
    cycles(4);
    check("R7 fail drives again", driveLow, 1'b1);
    powerFail = 1'b0;
    cycles(4);
    check("R9 no oscillator skips hold", driveLow, 1'b0);
    oscRunning = 1'b1;
    cycles(4);
  endtask

  task automatic testOverlap;
    // power fail interrupts a stretched pulse
    buttonDown = 1'b1;
    cycles(4);
    ticks(DEB);
    cycles(8);
    buttonDown = 1'b0;
    cycles(4);
    check("R4 pulse before overlap", driveLow, 1'b1);
    ticks(2);
    powerFail = 1'b1;
    cycles(4);
    check("R7 fail during pulse", driveLow, 1'b1);
    powerFail = 1'b0;
    cycles(4);
    ticks(REC - 1);
    check("R8 full recovery after pulse", driveLow, 1'b1);
    ticks(1);
    cycles(2);
    check("R8 ends after recovery", driveLow, 1'b0);
    // button held through a fail without oscillator
    buttonDown = 1'b1;
    cycles(4);
    powerFail = 1'b1;
    oscRunning = 1'b0;
    cycles(4);
    check("R7 fail during debounce", driveLow, 1'b1);
    powerFail = 1'b0;
    cycles(4);
    check("R9 release with button held", driveLow, 1'b0);
    ticks(DEB + 1);
    buttonDown = 1'b0;
    cycles(6);
    check("R6 release while idle ignored", driveLow, 1'b0);
    ticks(PUL + 1);
    check("R6 still idle", driveLow, 1'b0);
    oscRunning = 1'b1;
  endtask

  initial begin
    cycles(3);
    testReset();
    testLongPress();
    testShortPress();
    testPowerFail();
    testOverlap();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule